// File: doc/BRIEF.md
# Multi-Channel DAC Command Decoder

This block sits behind a serial command port and turns each committed 16-bit command word into register updates for twelve 8-bit converter channels. The low four bits of the word pick a target: one of the twelve channels, a special-function slot, or one of three expander functions. For channel and special-function targets, bits 7:4 act as a sub-opcode and bits 15:8 carry the converter code. The block keeps the twelve codes and one analog-enable flag for each of channels 5 to 12. Those channels share their pins with general-purpose expander I/O, so the flag chooses between driving the analog level and leaving the pin as a high-impedance input.

Expander commands are not decoded further here. They produce one-cycle strobes and a latched copy of the 12-bit setting field for the expander logic next to this block. A command is presented for one cycle with `cmd_valid`. All registered outputs reflect it after the next rising clock edge.

Top module: `dac_cmd_decoder`

## Requirements
- R1: Select 1 to 12 with sub-opcode 0000 loads bits 15:8 into that channel's code only. The channel's code appears on `dac_code_o[8*(c-1) +: 8]` and `ch_upd_o[c-1]` pulses, both one edge after the command.
- R2: A sub-opcode 0000 write to a channel from 5 to 12 also sets that channel's enable bit `ana_en_o[c-5]`. A write to channels 1 to 4 leaves every enable bit unchanged.
- R3: Select 5 to 12 with sub-opcode 0001 clears that channel's enable bit and keeps its code. The same sub-opcode sent to channels 1 to 4 changes nothing.
- R4: Select 0 with sub-opcode 1100 loads bits 15:8 into all twelve codes, sets all eight enable bits and pulses all twelve update strobes.
- R5: Select 0 with sub-opcode 1101 clears all eight enable bits and leaves every code unchanged, with no update strobe.
- R6: Select 0 with sub-opcode 1110 zeroes all codes, clears all enable bits and pulses all twelve update strobes.
- R7: Every other sub-opcode, for select 0 or for selects 1 to 12, changes no code, no enable bit and no strobe.
- R8: Select 13, 14 and 15 each pulse only `exp_wr_o`, `exp_rd_o` and `exp_cfg_o` respectively for one cycle, and latch bits 15:4 onto `exp_data_o`. These commands leave codes and enable bits unchanged.
- R9: Every strobe stays high for exactly one cycle. While `cmd_valid` is low, no output changes, whatever `cmd_word` carries.
- R10: After the reset input goes low, all codes, enable bits, strobes and `exp_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Execute strobe for `cmd_word` |
| cmd_word | input | 16 | Committed command: [3:0] select, [7:4] sub-opcode, [15:8] code |
| dac_code_o | output | 96 | Twelve 8-bit codes, channel c at bits 8*(c-1)+7:8*(c-1) |
| ana_en_o | output | 8 | Analog-enable for channels 5..12, bit 0 is channel 5 |
| ch_upd_o | output | 12 | Per-channel one-cycle strobe when the code register is loaded |
| exp_wr_o | output | 1 | Expander parallel-write strobe |
| exp_rd_o | output | 1 | Expander readback-request strobe |
| exp_cfg_o | output | 1 | Expander status-register write strobe |
| exp_data_o | output | 12 | Setting field of the last expander command |

## Verification
A single command can load a channel code and raise that channel's shared-pin enable in the same cycle. A broadcast does this for all twelve channels and eight flags at once. The bench provokes this by sweeping every select against every sub-opcode, in both directions, so that broadcasts, per-channel Hi-Z, Hi-Z-all and the soft reset each land on non-zero prior state. After each command it compares the codes, the enable vector, the strobe mask and the expander outputs together against an arithmetic model in the same sampled cycle. It compares them again one cycle later, with a scrambled word and the valid input low.

// File: rtl/dacdec_pkg.sv
package dacdec_pkg;
    localparam int SEL_W  = 4;
    localparam int SUB_W  = 4;
    localparam int CODE_W = 8;
    localparam int DATA_W = 12;

    localparam logic [SEL_W-1:0] SEL_SPECIAL = 4'd0;
    localparam logic [SEL_W-1:0] SEL_XWR     = 4'd13;
    localparam logic [SEL_W-1:0] SEL_XRD     = 4'd14;
    localparam logic [SEL_W-1:0] SEL_XCFG    = 4'd15;

    localparam logic [SUB_W-1:0] SUB_WRITE   = 4'b0000;
    localparam logic [SUB_W-1:0] SUB_HIZ     = 4'b0001;
    localparam logic [SUB_W-1:0] SUB_BCAST   = 4'b1100;
    localparam logic [SUB_W-1:0] SUB_HIZ_ALL = 4'b1101;
    localparam logic [SUB_W-1:0] SUB_RESET   = 4'b1110;

    typedef enum logic [3:0] {
        OP_NONE, OP_WR, OP_HIZ, OP_BCAST, OP_HIZ_ALL, OP_RST, OP_XWR, OP_XRD, OP_XCFG
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [SEL_W-1:0]  sel;
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] data;
    } dec_t;
endpackage

// File: rtl/dacdec_decode.sv
module dacdec_decode
    import dacdec_pkg::*;
#(
    parameter int NUM_CH       = 12,
    parameter int FIRST_SHARED = 5
) (
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    output dec_t        dec
);
    logic [SEL_W-1:0] sel;
    logic [SUB_W-1:0] sub;
    logic             is_chan;
    logic             is_shared;

    always_comb begin
        sel       = cmd_word[SEL_W-1:0];
        sub       = cmd_word[SEL_W+SUB_W-1:SEL_W];
        is_chan   = (int'(sel) >= 1) && (int'(sel) <= NUM_CH);
        is_shared = (int'(sel) >= FIRST_SHARED) && (int'(sel) <= NUM_CH);

        dec.op   = OP_NONE;
        dec.sel  = sel;
        dec.code = cmd_word[15:SEL_W+SUB_W];
        dec.data = cmd_word[15:SEL_W];

        if (cmd_valid) begin
            if (sel == SEL_SPECIAL) begin
                unique case (sub)
                    SUB_BCAST:   dec.op = OP_BCAST;
                    SUB_HIZ_ALL: dec.op = OP_HIZ_ALL;
                    SUB_RESET:   dec.op = OP_RST;
                    default:     dec.op = OP_NONE;
                endcase
            end else if (sel == SEL_XWR) begin
                dec.op = OP_XWR;
            end else if (sel == SEL_XRD) begin
                dec.op = OP_XRD;
            end else if (sel == SEL_XCFG) begin
                dec.op = OP_XCFG;
            end else if (is_chan && sub == SUB_WRITE) begin
                dec.op = OP_WR;
            end else if (is_shared && sub == SUB_HIZ) begin
                dec.op = OP_HIZ;
            end
        end
    end
endmodule

// File: rtl/dacdec_chan.sv
module dacdec_chan
    import dacdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q,
    output logic              upd_q
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              upd;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = load;
        if (load) begin
            st_d.code = code_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_q = st_q.code;
    assign upd_q  = st_q.upd;
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
    import dacdec_pkg::*;
#(
    parameter int NUM_CH       = 12,
    parameter int FIRST_SHARED = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [15:0]              cmd_word,
    output logic [NUM_CH*CODE_W-1:0] dac_code_o,
    output logic [NUM_CH-FIRST_SHARED:0] ana_en_o,
    output logic [NUM_CH-1:0]        ch_upd_o,
    output logic                     exp_wr_o,
    output logic                     exp_rd_o,
    output logic                     exp_cfg_o,
    output logic [DATA_W-1:0]        exp_data_o
);
    localparam int NUM_SHARED = NUM_CH - FIRST_SHARED + 1;

    typedef struct packed {
        logic [NUM_SHARED-1:0] en;
        logic                  xwr;
        logic                  xrd;
        logic                  xcfg;
        logic [DATA_W-1:0]     data;
    } top_t;

    dec_t dec;
    top_t st_d, st_q;

    dacdec_decode #(
        .NUM_CH      (NUM_CH),
        .FIRST_SHARED(FIRST_SHARED)
    ) u_decode (
        .cmd_valid(cmd_valid),
        .cmd_word (cmd_word),
        .dec      (dec)
    );

    for (genvar c = 1; c <= NUM_CH; c++) begin : g_chan
        logic              load;
        logic [CODE_W-1:0] code_in;
        always_comb begin
            load    = ((dec.op == OP_WR) && (dec.sel == SEL_W'(c)))
                   || (dec.op == OP_BCAST) || (dec.op == OP_RST);
            code_in = (dec.op == OP_RST) ? '0 : dec.code;
        end
        dacdec_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .code_in(code_in),
            .code_q (dac_code_o[(c-1)*CODE_W +: CODE_W]),
            .upd_q  (ch_upd_o[c-1])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.xwr  = (dec.op == OP_XWR);
        st_d.xrd  = (dec.op == OP_XRD);
        st_d.xcfg = (dec.op == OP_XCFG);
        if (st_d.xwr || st_d.xrd || st_d.xcfg) begin
            st_d.data = dec.data;
        end
        for (int k = 0; k < NUM_SHARED; k++) begin
            unique case (dec.op)
                OP_WR:                      if (dec.sel == SEL_W'(FIRST_SHARED + k)) st_d.en[k] = 1'b1;
                OP_HIZ:                     if (dec.sel == SEL_W'(FIRST_SHARED + k)) st_d.en[k] = 1'b0;
                OP_BCAST:                   st_d.en[k] = 1'b1;
                OP_HIZ_ALL, OP_RST:         st_d.en[k] = 1'b0;
                default:                    st_d.en[k] = st_q.en[k];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ana_en_o   = st_q.en;
    assign exp_wr_o   = st_q.xwr;
    assign exp_rd_o   = st_q.xrd;
    assign exp_cfg_o  = st_q.xcfg;
    assign exp_data_o = st_q.data;
endmodule

// File: rtl/dacdec_checker.sv
module dacdec_checker
    import dacdec_pkg::*;
#(
    parameter int NUM_CH       = 12,
    parameter int FIRST_SHARED = 5
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cmd_valid,
    input logic [15:0]                  cmd_word,
    input logic [NUM_CH*CODE_W-1:0]     dac_code_o,
    input logic [NUM_CH-FIRST_SHARED:0] ana_en_o,
    input logic [NUM_CH-1:0]            ch_upd_o,
    input logic                         exp_wr_o,
    input logic                         exp_rd_o,
    input logic                         exp_cfg_o
);
    assert_upd_needs_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_upd_o) |-> $past(cmd_valid));

    assert_code_change_strobed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code_o != $past(dac_code_o)) |-> (|ch_upd_o));

    assert_en_rise_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ana_en_o & ~$past(ana_en_o))) |-> $past(cmd_valid));

    assert_xwr_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exp_wr_o |-> ($past(cmd_valid) && $past(cmd_word[3:0]) == SEL_XWR));

    assert_xrd_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exp_rd_o |-> ($past(cmd_valid) && $past(cmd_word[3:0]) == SEL_XRD));

    assert_xcfg_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exp_cfg_o |-> ($past(cmd_valid) && $past(cmd_word[3:0]) == SEL_XCFG));

    assert_exp_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exp_wr_o, exp_rd_o, exp_cfg_o}));

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_upd_o) |-> !(exp_wr_o || exp_rd_o || exp_cfg_o));

    assert_bcast_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_valid) && $past(cmd_word[7:0]) == 8'hC0) |-> ((&ch_upd_o) && (&ana_en_o)));
endmodule

bind dac_cmd_decoder dacdec_checker #(
    .NUM_CH      (NUM_CH),
    .FIRST_SHARED(FIRST_SHARED)
) u_chk (.*);

// File: tb/dac_cmd_decoder_bench.sv
`timescale 1ns/1ps
module dac_cmd_decoder_bench;
    localparam int NCH = 12;
    localparam int FS  = 5;
    localparam int NSH = NCH - FS + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [15:0]       cmd_word = '0;
    logic [NCH*8-1:0]  dac_code_o;
    logic [NSH-1:0]    ana_en_o;
    logic [NCH-1:0]    ch_upd_o;
    logic              exp_wr_o, exp_rd_o, exp_cfg_o;
    logic [11:0]       exp_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NCH*8-1:0] m_code;
    logic [NSH-1:0]   m_en;
    logic [NCH-1:0]   m_upd;
    logic [2:0]       m_x;
    logic [11:0]      m_data;

    always #2.5 clk = ~clk;

    dac_cmd_decoder u_dac_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .dac_code_o(dac_code_o), .ana_en_o(ana_en_o), .ch_upd_o(ch_upd_o),
        .exp_wr_o(exp_wr_o), .exp_rd_o(exp_rd_o), .exp_cfg_o(exp_cfg_o),
        .exp_data_o(exp_data_o)
    );

    task automatic chk(string tag, string what, logic [NCH*8-1:0] act, logic [NCH*8-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "codes", dac_code_o, m_code);
        chk(tag, "enables", {{(NCH*8-NSH){1'b0}}, ana_en_o}, {{(NCH*8-NSH){1'b0}}, m_en});
        chk(tag, "update strobes", {{(NCH*8-NCH){1'b0}}, ch_upd_o}, {{(NCH*8-NCH){1'b0}}, m_upd});
        chk(tag, "expander strobes", {{(NCH*8-3){1'b0}}, exp_wr_o, exp_rd_o, exp_cfg_o},
            {{(NCH*8-3){1'b0}}, m_x});
        chk(tag, "expander data", {{(NCH*8-12){1'b0}}, exp_data_o}, {{(NCH*8-12){1'b0}}, m_data});
    endtask

    function automatic string tag_of(logic [15:0] w);
        int s = int'(w[3:0]);
        int u = int'(w[7:4]);
        if (s == 0) begin
            if (u == 12) return "R4";
            if (u == 13) return "R5";
            if (u == 14) return "R6";
            return "R7";
        end
        if (s >= 13) return "R8";
        if (u == 0) return (s >= FS) ? "R2" : "R1";
        if (u == 1) return "R3";
        return "R7";
    endfunction

    task automatic model(logic [15:0] w);
        int s = int'(w[3:0]);
        int u = int'(w[7:4]);
        m_upd = '0;
        m_x   = '0;
        if (s == 0) begin
            if (u == 12) begin
                for (int c = 0; c < NCH; c++) m_code[c*8 +: 8] = w[15:8];
                m_en = '1; m_upd = '1;
            end else if (u == 13) begin
                m_en = '0;
            end else if (u == 14) begin
                m_code = '0; m_en = '0; m_upd = '1;
            end
        end else if (s >= 13) begin
            m_x = (s == 13) ? 3'b100 : (s == 14) ? 3'b010 : 3'b001;
            m_data = w[15:4];
        end else if (u == 0) begin
            m_code[(s-1)*8 +: 8] = w[15:8];
            m_upd[s-1] = 1'b1;
            if (s >= FS) m_en[s-FS] = 1'b1;
        end else if (u == 1 && s >= FS) begin
            m_en[s-FS] = 1'b0;
        end
    endtask

    task automatic send(logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        model(w);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = ~w;
        check_all(tag_of(w));
        m_upd = '0;
        m_x   = '0;
        @(negedge clk);
        check_all("R9");
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_code = '0; m_en = '0; m_upd = '0; m_x = '0; m_data = '0;
        repeat (3) @(negedge clk);
        check_all("R10");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10");
        // R9: idle words with valid low
        for (int i = 0; i < 4; i++) begin
            cmd_word = 16'hC0 + 16'(i * 16'h1111);
            @(negedge clk);
            check_all("R9");
        end
        // R2 and R3 directed
        for (int c = 1; c <= NCH; c++) send({8'(c * 19 + 7), 4'b0000, 4'(c)});
        send({8'h5A, 4'b0001, 4'd7});
        send({8'h5A, 4'b0001, 4'd2});
        // Reverse sweep: channel state builds before special functions
        for (int s = 15; s >= 0; s--)
            for (int u = 0; u < 16; u++)
                send({8'((s * 37 + u * 11 + 5) & 255), 4'(u), 4'(s)});
        // Forward sweep
        for (int s = 0; s < 16; s++)
            for (int u = 15; u >= 0; u--)
                send({8'((s * 53 + u * 29 + 1) & 255), 4'(u), 4'(s)});
        // R5 after fresh broadcast
        send(16'hA5C0);
        send(16'h00D0);
        // R6 with non-zero state
        send(16'h3C05);
        send(16'h00E0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule